// File: doc/BRIEF.md
# Transfer Length Command Splitter

The splitter turns one byte count into the list of command entries a serial-flash sequencer needs to move exactly that many bytes. A start pulse captures the length, a base command word (direction, bus and select bits) and an alignment flag. The block then presents entries one at a time on a valid/ready output until the whole length is covered.

Any length above 255 is consumed in power-of-two pieces. Each piece is coded as an exponent entry. The search for the next piece begins at bit 8 of the remaining count and moves upward to the first set bit. Once the remainder fits in 8 bits, one immediate entry carries it. When alignment is on, a remainder that is not a multiple of four is padded up to the next multiple of four. Every entry reports its byte count on a side port, so a data mover can be sized from it. A single-cycle done pulse marks the end of the list.

Top module: `xfer_len_splitter`

## Requirements
- R1: While reset is asserted and directly after it, cmd_valid_o and done_o are both low.
- R2: A start with a length of zero emits no entry. done_o is high for exactly one cycle, in the cycle after the start edge.
- R3: A length from 1 to 255 with alignment off gives exactly one entry. Bit 9 of that entry is 0, bits 7:0 hold the length, and cmd_bytes_o equals the length.
- R4: While the remaining count is above 255, the next entry sets bit 9 to 1 and puts e in bits 7:0, with cmd_bytes_o = 2^e. Here e is the lowest set bit of the remaining count at position 8 or above, and 2^e is then removed from the count.
- R5: A remaining count that reaches zero after exponent entries ends the list with no immediate entry. Otherwise exactly one immediate entry follows, carrying the leftover count.
- R6: With alignment on, an immediate remainder that is not a multiple of 4 is raised to the next multiple of 4 in both bits 7:0 and cmd_bytes_o. Multiples of 4 and exponent entries are left unchanged.
- R7: With alignment on, a remainder of 253 to 255 rounds to 256. It is emitted as an exponent entry with e = 8 and cmd_bytes_o = 256.
- R8: Every entry copies the base command captured at start, except for bits 7:0 and bit 9, which are replaced. This means a base value in those bits never reaches the output.
- R9: While cmd_valid_o is high and cmd_ready_i is low, cmd_o and cmd_bytes_o hold their values and cmd_valid_o stays high.
- R10: done_o rises for exactly one cycle, in the cycle after the last entry is accepted. It is never high together with cmd_valid_o.
- R11: A start pulse that arrives while entries are still pending is ignored.
- R12: len_i, base_cmd_i and align_rx_i are sampled only at start. Later changes to them do not alter the entries in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures the three inputs below when idle |
| len_i | input | LEN_W | Byte count to cover |
| base_cmd_i | input | CMD_W | Base command word; bits 7:0 and 9 are overwritten |
| align_rx_i | input | 1 | Round the final immediate up to a multiple of 4 |
| cmd_ready_i | input | 1 | Consumer accepts the current entry |
| cmd_valid_o | output | 1 | An entry is presented |
| cmd_o | output | CMD_W | Command entry: bit 9 exponent flag, bits 7:0 immediate |
| cmd_bytes_o | output | LEN_W | Bytes covered by the presented entry |
| done_o | output | 1 | One-cycle pulse after the list ends |

## Verification
The bench aims at four kinds of count. The first is counts with several set bits above bit 7, where a splitter that takes the highest bit first, or does not restart the scan at bit 8, puts out entries in the wrong order. The second is exact multiples of 256, where an extra zero-length immediate would show up. The third is aligned remainders of 253 to 255, where a truncating 8-bit field would produce an immediate of 0 instead of a 256-byte exponent entry. The fourth is all-ones base words, which expose any base bit leaking into the immediate or the exponent flag. Throttled ready patterns, a repeated start pulse during a transfer, and inputs that change after start catch a design that drops entries, accepts a second start, or re-reads its inputs.

// File: rtl/xfer_split_pkg.sv
package xfer_split_pkg;
  localparam int IMM_W   = 8;
  localparam int EXP_BIT = 9;
  localparam int IMM_MAX = (1 << IMM_W) - 1;

  typedef struct packed {
    logic             is_exp;
    logic [IMM_W-1:0] imm;
  } entry_field_t;
endpackage

// File: rtl/xfer_chunk_enc.sv
module xfer_chunk_enc
  import xfer_split_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic [LEN_W-1:0] rem_i,
  input  logic             align_i,
  output entry_field_t     field_o,
  output logic [LEN_W-1:0] bytes_o,
  output logic             last_o
);
  localparam int IDX_W = $clog2(LEN_W);

  logic             big;
  logic [IDX_W-1:0] e_idx;
  logic [IMM_W:0]   small9, rnd9;

  assign big    = |rem_i[LEN_W-1:IMM_W];
  assign small9 = {1'b0, rem_i[IMM_W-1:0]};

  // lowest set bit at or above IMM_W
  always_comb begin
    e_idx = IDX_W'(IMM_W);
    for (int i = LEN_W - 1; i >= IMM_W; i--) begin
      if (rem_i[i]) e_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (align_i && (|small9[1:0])) rnd9 = (small9 + (IMM_W+1)'(3)) & {{(IMM_W-1){1'b1}}, 2'b00};
    else                           rnd9 = small9;
  end

  always_comb begin
    if (big) begin
      field_o.is_exp = 1'b1;
      field_o.imm    = IMM_W'(e_idx);
      bytes_o        = {{(LEN_W-1){1'b0}}, 1'b1} << e_idx;
      last_o         = (rem_i == bytes_o);
    end else if (rnd9[IMM_W]) begin
      // rounded remainder overflowed the immediate: one 2^IMM_W chunk
      field_o.is_exp = 1'b1;
      field_o.imm    = IMM_W'(IMM_W);
      bytes_o        = LEN_W'(rnd9);
      last_o         = 1'b1;
    end else begin
      field_o.is_exp = 1'b0;
      field_o.imm    = rnd9[IMM_W-1:0];
      bytes_o        = LEN_W'(rnd9);
      last_o         = 1'b1;
    end
  end
endmodule

// File: rtl/xfer_cmd_fmt.sv
module xfer_cmd_fmt
  import xfer_split_pkg::*;
#(
  parameter int CMD_W = 32
) (
  input  logic [CMD_W-1:0] base_i,
  input  entry_field_t     field_i,
  output logic [CMD_W-1:0] cmd_o
);
  always_comb begin
    cmd_o            = base_i;
    cmd_o[IMM_W-1:0] = field_i.imm;
    cmd_o[EXP_BIT]   = field_i.is_exp;
  end
endmodule

// File: rtl/xfer_len_splitter.sv
module xfer_len_splitter
  import xfer_split_pkg::*;
#(
  parameter int LEN_W = 32,
  parameter int CMD_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [CMD_W-1:0] base_cmd_i,
  input  logic             align_rx_i,
  input  logic             cmd_ready_i,
  output logic             cmd_valid_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [LEN_W-1:0] cmd_bytes_o,
  output logic             done_o
);
  logic             busy_q, done_q, align_q;
  logic [LEN_W-1:0] rem_q;
  logic [CMD_W-1:0] base_q;
  entry_field_t     field;
  logic [LEN_W-1:0] chunk_bytes;
  logic             chunk_last;
  logic             hs;

  xfer_chunk_enc #(.LEN_W(LEN_W)) u_enc (
    .rem_i   (rem_q),
    .align_i (align_q),
    .field_o (field),
    .bytes_o (chunk_bytes),
    .last_o  (chunk_last)
  );

  xfer_cmd_fmt #(.CMD_W(CMD_W)) u_fmt (
    .base_i  (base_q),
    .field_i (field),
    .cmd_o   (cmd_o)
  );

  assign hs          = busy_q && cmd_ready_i;
  assign cmd_valid_o = busy_q;
  assign cmd_bytes_o = chunk_bytes;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      align_q <= 1'b0;
      rem_q   <= '0;
      base_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          rem_q   <= len_i;
          base_q  <= base_cmd_i;
          align_q <= align_rx_i;
          if (len_i == '0) done_q <= 1'b1;
          else             busy_q <= 1'b1;
        end
      end else if (hs) begin
        if (chunk_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rem_q  <= '0;
        end else begin
          rem_q <= rem_q - chunk_bytes;
        end
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |=> !cmd_valid_o && !done_o);

  assert_exp_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_o[EXP_BIT] |-> $onehot(cmd_bytes_o) && (cmd_bytes_o > LEN_W'(IMM_MAX)));

  assert_imm_ends_list_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i && !cmd_o[EXP_BIT] |=> !cmd_valid_o && done_o);

  assert_align_imm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && align_q && !cmd_o[EXP_BIT] |-> cmd_o[1:0] == 2'b00);

  assert_base_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !$rose(cmd_valid_o) |->
      (cmd_o[CMD_W-1:EXP_BIT+1] == $past(cmd_o[CMD_W-1:EXP_BIT+1])) && (cmd_o[IMM_W] == $past(cmd_o[IMM_W])));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_o) && $stable(cmd_bytes_o));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && cmd_valid_o));

  assert_busy_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i && start_i |=> cmd_valid_o && !done_o);
endmodule

// File: tb/xfer_len_splitter_tb_top.sv
module xfer_len_splitter_tb_top;
  localparam int LEN_W = 32;
  localparam int CMD_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [LEN_W-1:0] len_i = '0;
  logic [CMD_W-1:0] base_cmd_i = '0;
  logic             align_rx_i = 1'b0;
  logic             cmd_ready_i = 1'b0;
  logic             cmd_valid_o;
  logic [CMD_W-1:0] cmd_o;
  logic [LEN_W-1:0] cmd_bytes_o;
  logic             done_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  xfer_len_splitter #(.LEN_W(LEN_W), .CMD_W(CMD_W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start_i),
    .len_i       (len_i),
    .base_cmd_i  (base_cmd_i),
    .align_rx_i  (align_rx_i),
    .cmd_ready_i (cmd_ready_i),
    .cmd_valid_o (cmd_valid_o),
    .cmd_o       (cmd_o),
    .cmd_bytes_o (cmd_bytes_o),
    .done_o      (done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  logic [31:0] q_cmd[$];
  logic [31:0] q_bytes[$];

  function automatic logic [31:0] mk(input logic [31:0] base, input bit ex, input int imm);
    logic [31:0] c;
    c = base & ~32'h0000_02FF;
    if (ex) c = c | 32'h0000_0200;
    c = c | (imm & 32'hFF);
    return c;
  endfunction

  task automatic build(input logic [31:0] len, input logic [31:0] base, input bit align);
    longint rem;
    q_cmd.delete();
    q_bytes.delete();
    rem = len;
    while (rem != 0) begin
      if (rem > 255) begin
        int e;
        e = 8;
        while (((rem >> e) & 1) == 0) e++;
        q_cmd.push_back(mk(base, 1'b1, e));
        q_bytes.push_back(32'(64'd1 << e));
        rem = rem - (64'd1 << e);
      end else begin
        int r;
        r = int'(rem);
        if (align && (r % 4) != 0) r = ((r + 3) / 4) * 4;
        if (r == 256) begin
          q_cmd.push_back(mk(base, 1'b1, 8));
          q_bytes.push_back(32'd256);
        end else begin
          q_cmd.push_back(mk(base, 1'b0, r));
          q_bytes.push_back(32'(r));
        end
        rem = 0;
      end
    end
  endtask

  task automatic run(input logic [31:0] len, input logic [31:0] base, input bit align,
                     input int rmode, input bit poke, input string req);
    int cyc;
    build(len, base, align);
    @(negedge clk);
    start_i = 1'b1; len_i = len; base_cmd_i = base; align_rx_i = align; cmd_ready_i = 1'b0;
    @(negedge clk);
    // R12: scramble inputs after capture
    start_i = 1'b0; len_i = ~len; base_cmd_i = ~base; align_rx_i = ~align;
    cyc = 0;
    forever begin
      if (q_cmd.size() == 0) begin
        chk(done_o === 1'b1, "R10 done after last", 64'(done_o), 64'd1);
        chk(cmd_valid_o === 1'b0, "R10 no valid with done", 64'(cmd_valid_o), 64'd0);
        cmd_ready_i = 1'b0;
        @(negedge clk);
        chk(done_o === 1'b0, "R10 done one cycle", 64'(done_o), 64'd0);
        break;
      end
      begin
        bit rdy;
        string tag;
        tag = (cyc > 0 && !cmd_ready_i) ? "R9" : req;
        chk(cmd_valid_o === 1'b1 && done_o === 1'b0, tag, {cmd_valid_o, done_o}, 2'b10);
        chk(cmd_o === q_cmd[0], tag, 64'(cmd_o), 64'(q_cmd[0]));
        chk(cmd_bytes_o === q_bytes[0], tag, 64'(cmd_bytes_o), 64'(q_bytes[0]));
        rdy = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
        cmd_ready_i = rdy;
        // R11: start while busy
        start_i = poke && (cyc == 1);
        if (rdy) begin
          void'(q_cmd.pop_front());
          void'(q_bytes.pop_front());
        end
      end
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
      if (cyc > 5000) begin
        chk(1'b0, "stuck transfer", 64'(cyc), 64'd0);
        break;
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    chk(cmd_valid_o === 1'b0 && done_o === 1'b0, "R1 in reset", {cmd_valid_o, done_o}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_valid_o === 1'b0 && done_o === 1'b0, "R1 after reset", {cmd_valid_o, done_o}, 2'b00);

    run(32'd0,          32'h0001_5000, 1'b0, 0, 1'b0, "R2");
    run(32'd1,          32'h0001_5000, 1'b0, 0, 1'b0, "R3");
    run(32'd255,        32'hFFFF_FFFF, 1'b0, 1, 1'b0, "R3 R8");
    run(32'd256,        32'h0002_5000, 1'b0, 0, 1'b0, "R5");
    run(32'h0000_0301,  32'hFFFF_FFFF, 1'b0, 1, 1'b1, "R4 R8 R11");
    run(32'h0001_F0A3,  32'h0001_5000, 1'b0, 1, 1'b0, "R4");
    run(32'h0000_0E00,  32'h0002_5000, 1'b1, 0, 1'b0, "R5");
    run(32'd5,          32'h0002_5000, 1'b1, 0, 1'b0, "R6");
    run(32'd8,          32'h0002_5000, 1'b1, 0, 1'b0, "R6");
    run(32'h0000_0103,  32'hFFFF_FFFF, 1'b1, 1, 1'b1, "R6 R11");
    run(32'd254,        32'h0002_5000, 1'b1, 1, 1'b0, "R7");
    run(32'h0000_05FF,  32'hFFFF_FFFF, 1'b1, 0, 1'b0, "R7");
    run(32'h8000_0001,  32'h0001_5000, 1'b0, 1, 1'b1, "R4 R12");
    run(32'd0,          32'hFFFF_FFFF, 1'b1, 0, 1'b0, "R2");

    lf = 32'hACE1_2345;
    for (int k = 0; k < 24; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run(lf & 32'h000F_FFFF, {lf[7:0], lf[31:8]}, lf[3], k % 2, lf[5], "R4 R12");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule